// File: doc/BRIEF.md
# Asynchronous Host RAM Bridge

This block lets a host processor reach a 4096 x 16 word RAM that lives inside a controller clocked by one main clock. The host side is strobe-driven and fully asynchronous: active-low chip-enable, write-enable and output-enable, a 12-bit address and a bidirectional 16-bit data bus. None of the host signals has a setup or hold relationship to the main clock.

Chip-enable and write-enable pass through multi-flop synchronizers. A handshake state machine waits until the synchronized chip-enable has been low for two cycles. It then captures the address, the direction and the write data, and performs one access on the RAM's single synchronous port. It reports completion by driving the active-low ready output. An internal-busy input stands for other controller activity: while it is high, the pending access waits. Ready stays low until the host releases chip-enable, so the host sees a full four-phase handshake.

Top module: `hb_host_bridge`

## Requirements
- R1: After reset, ready (`host_rdy_no`) is high and the bridge does not drive the data bus.
- R2: A write stores the bus value at the given address. Ready falls no earlier than 4 main-clock cycles after chip-enable falls, and no later than 8 cycles when busy stays low.
- R3: A read returns the word stored at the given address, valid on the bus while ready is low. Ready falls no earlier than 5 cycles after chip-enable falls, and no later than 8 cycles when busy stays low.
- R4: The bridge drives the data bus only while chip-enable and output-enable are both low. Otherwise it leaves the bus at high impedance, so another driver's value is seen unchanged.
- R5: Once low, ready stays low until the host raises chip-enable. It then returns high within 4 cycles.
- R6: While `busy_i` is high, no pending access completes and ready stays high. The access completes once busy falls.
- R7: The address and write data are captured before ready falls. Changing them afterwards, while chip-enable is still low, does not alter what was written.
- R8: A read leaves the RAM contents unchanged.
- R9: Ready falls only after a RAM access has taken place for the current handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 12 | Host word address |
| host_data_io | inout | 16 | Host data bus, tristate |
| host_ce_ni | input | 1 | Chip-enable, active low |
| host_we_ni | input | 1 | Write-enable, active low (high means read) |
| host_oe_ni | input | 1 | Output-enable, active low |
| host_rdy_no | output | 1 | Access complete, active low |
| busy_i | input | 1 | Internal activity; holds the pending access |

## Verification
On every cycle, the assertions check the following:
- A RAM write is never issued while busy is high.
- Ready falls only while the synchronized chip-enable is low, and only right after a RAM access.
- Ready holds low until chip-enable is seen high, then rises.

Only the bench scenarios can show that each address holds the word written to it, and that read data reach the pins. They also measure the latencies from the asynchronous chip-enable edge. They confirm that the bus is released when either enable is high, and that address or data changes after ready are ignored.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARM    = 3'd1,
    ST_CMD    = 3'd2,
    ST_RDWAIT = 3'd3,
    ST_DONE   = 3'd4
  } hs_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_ram.sv
module hb_ram #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_s_ni,
  input  logic          we_s_ni,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rdy_no
);
  hs_state_e state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic          wr_q;
  logic          rdy_q;

  always_comb begin
    state_d  = state_q;
    ram_en_o = 1'b0;
    ram_we_o = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (!ce_s_ni) state_d = ST_ARM;
      ST_ARM:    state_d = ce_s_ni ? ST_IDLE : ST_CMD;
      ST_CMD: begin
        if (!busy_i) begin
          ram_en_o = 1'b1;
          ram_we_o = wr_q;
          state_d  = wr_q ? ST_DONE : ST_RDWAIT;
        end
      end
      ST_RDWAIT: state_d = ST_DONE;
      ST_DONE:   if (ce_s_ni) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= '0;
      rdy_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      rdy_q   <= (state_d != ST_DONE);
      // capture once ce has been low for two synchronized cycles
      if (state_q == ST_ARM && !ce_s_ni) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        wr_q    <= !we_s_ni;
      end
      if (state_q == ST_RDWAIT) rd_q <= ram_rdata_i;
    end
  end

  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = wdata_q;
  assign rd_data_o   = rd_q;
  assign rdy_no      = rdy_q;

  logic acc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= 1'b0;
    else if (ram_en_o) acc_q <= 1'b1;
    else if (state_q == ST_IDLE) acc_q <= 1'b0;
  end

  // R6: no RAM write while internal activity is flagged
  a_r6_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> !busy_i);

  // R2: a write is followed by ready low
  a_r2_write_then_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !rdy_no);

  // R5: ready holds low while ce is still seen low
  a_r5_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no && !ce_s_ni) |=> !rdy_no);

  // R5: seeing ce high releases ready
  a_r5_ready_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_s_ni |=> rdy_no);

  // R9: ready only falls after an access in this handshake
  a_r9_access_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> (acc_q || $past(ram_en_o)));
endmodule

// File: rtl/hb_host_bridge.sv
module hb_host_bridge
  import hb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  inout  wire  [DATA_W-1:0] host_data_io,
  input  logic              host_ce_ni,
  input  logic              host_we_ni,
  input  logic              host_oe_ni,
  output logic              host_rdy_no,
  input  logic              busy_i
);
  logic              ce_s_n, we_s_n;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata, rd_data;
  logic              drive_en;

  hb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({host_we_ni, host_ce_ni}),
    .q_o    ({we_s_n, ce_s_n})
  );

  hb_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_s_ni     (ce_s_n),
    .we_s_ni     (we_s_n),
    .busy_i      (busy_i),
    .addr_i      (host_addr_i),
    .wdata_i     (host_data_io),
    .ram_en_o    (ram_en),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata),
    .rd_data_o   (rd_data),
    .rdy_no      (host_rdy_no)
  );

  hb_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  // bus enable follows the raw pins: output turn-on needs no synchronizer
  assign drive_en     = !host_ce_ni && !host_oe_ni;
  assign host_data_io = drive_en ? rd_data : 'z;

  // R1: ready is high on the first cycle out of reset
  a_r1_reset_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> host_rdy_no);
endmodule

// File: tb/hb_host_bridge_tb.sv
module hb_host_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic        tb_drv = 1'b0;
  logic [15:0] tb_val = '0;
  wire  [15:0] data_w;
  logic        rdy_n;

  int checks = 0, fails = 0;
  bit done = 0;

  assign data_w = tb_drv ? tb_val : 'z;

  always #10 clk = ~clk;

  hb_host_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_data_io(data_w),
    .host_ce_ni(ce_n), .host_we_ni(we_n), .host_oe_ni(oe_n),
    .host_rdy_no(rdy_n), .busy_i(busy)
  );

  function automatic logic [15:0] pat(input int a, input int seed);
    return 16'((a * 40503 + seed * 7919) ^ 16'h5A3C);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_rdy_low(output int cyc);
    cyc = 0;
    while (rdy_n && cyc < 200) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
  endtask

  task automatic release_ce(input bit chk_rel);
    int c = 0;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
    while (!rdy_n && c < 20) begin
      @(posedge clk); @(negedge clk); c++;
    end
    if (chk_rel) chk(rdy_n && c <= 4, "R5 release", c, 4);
  endtask

  task automatic host_write(input logic [11:0] a, input logic [15:0] d, input bit lat_chk);
    int cyc;
    addr = a; we_n = 1'b0; tb_val = d; tb_drv = 1'b1;
    ce_n = 1'b0;
    wait_rdy_low(cyc);
    if (lat_chk) chk(cyc >= 4 && cyc <= 8, "R2 write latency", cyc, 5);
    release_ce(lat_chk);
  endtask

  task automatic host_read(input logic [11:0] a, output logic [15:0] d, output int cyc);
    addr = a; we_n = 1'b1; oe_n = 1'b0; tb_drv = 1'b0;
    ce_n = 1'b0;
    wait_rdy_low(cyc);
    d = data_w;
  endtask

  initial begin
    int cyc;
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    chk(rdy_n === 1'b1, "R1 ready in reset", rdy_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_n === 1'b1, "R1 ready after reset", rdy_n, 1);
    tb_drv = 1'b1; tb_val = 16'hC3A5;
    @(negedge clk);
    chk(data_w === 16'hC3A5, "R1 bus released", data_w, 16'hC3A5);
    tb_drv = 1'b0;

    // full sweep: write every address, then read every address back
    for (int a = 0; a < 4096; a++) host_write(12'(a), pat(a, 1), a < 16);
    for (int a = 0; a < 4096; a++) begin
      host_read(12'(a), rd, cyc);
      if (a < 16 || a > 4088) begin
        chk(cyc >= 5 && cyc <= 8, "R3 read latency", cyc, 6);
        @(negedge clk);
        chk(!rdy_n && data_w === rd, "R5 ready and data held", data_w, rd);
      end
      chk(rd === pat(a, 1), "R3 read data", rd, pat(a, 1));
      release_ce(a < 16);
    end

    // R8: reads do not disturb contents
    for (int a = 0; a < 64; a++) begin
      host_read(12'(a * 61), rd, cyc);
      chk(rd === pat(a * 61, 1), "R8 reread", rd, pat(a * 61, 1));
      release_ce(1'b0);
    end

    // R4: oe high during read leaves the bus to another driver
    host_write(12'h123, 16'h0F0F, 1'b1);
    addr = 12'h123; we_n = 1'b1; oe_n = 1'b1; tb_val = 16'hF000; tb_drv = 1'b1;
    ce_n = 1'b0;
    wait_rdy_low(cyc);
    chk(data_w === 16'hF000, "R4 oe high not driven", data_w, 16'hF000);
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    chk(data_w === 16'hF000, "R4 ce high not driven", data_w, 16'hF000);
    release_ce(1'b1);
    host_read(12'h123, rd, cyc);
    chk(rd === 16'h0F0F, "R4 driven when both low", rd, 16'h0F0F);
    release_ce(1'b0);

    // R7: address/data changes after ready are ignored
    addr = 12'h200; we_n = 1'b0; tb_val = 16'hBEEF; tb_drv = 1'b1; ce_n = 1'b0;
    wait_rdy_low(cyc);
    addr = 12'h201; tb_val = 16'h1111;
    repeat (3) @(negedge clk);
    release_ce(1'b1);
    host_read(12'h200, rd, cyc);
    chk(rd === 16'hBEEF, "R7 data kept", rd, 16'hBEEF);
    release_ce(1'b0);
    host_read(12'h201, rd, cyc);
    chk(rd === pat(16'h201, 1), "R7 neighbour untouched", rd, pat(16'h201, 1));
    release_ce(1'b0);

    // R6: busy stalls completion
    busy = 1'b1;
    addr = 12'h3FF; we_n = 1'b0; tb_val = 16'h7E57; tb_drv = 1'b1; ce_n = 1'b0;
    repeat (20) @(negedge clk);
    chk(rdy_n === 1'b1, "R6 ready held by busy", rdy_n, 1);
    busy = 1'b0;
    wait_rdy_low(cyc);
    chk(cyc <= 3, "R6 completes after busy", cyc, 1);
    release_ce(1'b1);
    busy = 1'b1;
    host_read(12'h3FF, rd, cyc);
    chk(cyc == 200, "R6 read stalled", cyc, 200);
    busy = 1'b0;
    wait_rdy_low(cyc);
    chk(data_w === 16'h7E57, "R6 write landed", data_w, 16'h7E57);
    release_ce(1'b0);

    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 190000) begin
      @(posedge clk); n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule